// File: doc/BRIEF.md
# Write-Absorbing Persistent Address Cache

This block sits on the path from a processor memory port to a main memory whose cells wear out after a limited number of writes. A small table of word addresses, chosen ahead of time because software writes them often, is loaded through a configuration port. Reads and writes to those addresses are served from a fast volatile entry, so the main memory never sees them. Every other access passes straight through to the main memory, and the block waits for that memory's ready handshake.

Each entry has a non-volatile shadow copy. After reset, and again after each wake-up, a sequencer copies every shadow into its volatile entry, one entry per cycle. The processor port is stalled while this runs. A power-down request starts the opposite sequence: each volatile entry is copied to its shadow, the block reports completion and stays off, with its volatile data lost, until it is woken. Two counters record how many writes reached the main memory and how many the cache absorbed, so that a testbench can measure how much wear is saved.

Top module: `persist_wcache`

## Requirements
- R1: After reset the block runs a restore of N_ENTRY cycles, during which cpu_ready_o and mem_req_o stay low. restore_done_o is high for exactly one cycle, the first cycle in which accesses are accepted.
- R2: The restore copies each entry's shadow into its volatile data. The shadow is zero after reset, and a restore leaves each entry holding the value stored by the last save.
- R3: A configuration write (cfg_we_i) sets entry cfg_idx_i to address cfg_addr_i with valid bit cfg_valid_i. It takes effect only while accesses are accepted and is ignored during restore, save and off.
- R4: A read whose address matches a valid entry completes in the same cycle: cpu_ready_o is high, cpu_rdata_o is the entry's data, and mem_req_o stays low.
- R5: A write whose address matches a valid entry updates that entry only. It completes in the same cycle, issues no main-memory request, and increments absorb_cnt_o by one.
- R6: An access that matches no valid entry drives mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o from the processor inputs unchanged. cpu_ready_o follows mem_ready_i and cpu_rdata_o follows mem_rdata_i. Each completed forwarded write increments mem_wr_cnt_o by one.
- R7: A pdn_req_i sampled while accesses are accepted starts a save of N_ENTRY cycles, one entry per cycle. After the save the block is off: save_done_o is high, cpu_ready_o is low, and the volatile data reads as zero.
- R8: wake_i sampled while the block is off starts a restore. Once restore_done_o has pulsed, every covered address reads back the value it held when the save began.
- R9: A pdn_req_i that arrives during a restore is held. The save begins in the cycle right after the restore ends, with no cycle in which accesses are accepted.
- R10: When several valid entries match the same address, the entry with the lowest index serves both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IW | Entry index to configure |
| cfg_valid_i | input | 1 | Valid bit written to the entry |
| cfg_addr_i | input | AW | Word address covered by the entry |
| pdn_req_i | input | 1 | Power-down request |
| wake_i | input | 1 | Power-up request while off |
| restore_done_o | output | 1 | One-cycle pulse when a restore finishes |
| save_done_o | output | 1 | High while off after a save |
| cpu_req_i | input | 1 | Processor access request, held until ready |
| cpu_we_i | input | 1 | Processor write enable |
| cpu_addr_i | input | AW | Processor word address |
| cpu_wdata_i | input | DW | Processor write data |
| cpu_ready_o | output | 1 | Access completes this cycle |
| cpu_rdata_o | output | DW | Read data |
| mem_req_o | output | 1 | Main-memory request |
| mem_we_o | output | 1 | Main-memory write enable |
| mem_addr_o | output | AW | Main-memory word address |
| mem_wdata_o | output | DW | Main-memory write data |
| mem_ready_i | input | 1 | Main-memory handshake |
| mem_rdata_i | input | DW | Main-memory read data |
| mem_wr_cnt_o | output | CW | Writes completed at main memory |
| absorb_cnt_o | output | CW | Writes absorbed by the cache |

## Verification
The assertions check on every cycle that the processor port and the main-memory port stay quiet outside the accepting phase, and that a hit never reaches the main memory. They also check that each counter moves only after a matching completed write, that a save lasts exactly N_ENTRY cycles, that a deferred power-down moves straight from restore into save, and that the restore-done flag is a single pulse. Only the bench's scenarios can show the data itself. These scenarios cover the values that survive a save, off and wake cycle, lowest-index priority between duplicate tags, configuration writes dropped while off, and pass-through data from the memory model.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    PH_RESTORE = 2'd0,
    PH_RUN     = 2'd1,
    PH_SAVE    = 2'd2,
    PH_OFF     = 2'd3
  } phase_e;
endpackage

// File: rtl/pwc_tag_match.sv
module pwc_tag_match #(
  parameter int N  = 16,
  parameter int AW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         valid_i,
  input  logic [N-1:0][AW-1:0] tag_i,
  input  logic [AW-1:0]        addr_i,
  output logic                 hit_o,
  output logic [IW-1:0]        idx_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tag_i[g] == addr_i);
  end

  // lowest index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = i[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/pwc_entry_store.sv
module pwc_entry_store #(
  parameter int N  = 16,
  parameter int DW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IW-1:0]        wr_idx_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic [IW-1:0]        seq_idx_i,
  input  logic                 restore_i,
  input  logic                 save_i,
  input  logic                 wipe_i,
  output logic [N-1:0][DW-1:0] data_o
);
  logic [DW-1:0] data_q   [N];
  logic [DW-1:0] shadow_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    localparam logic [IW-1:0] MY_IDX = IW'(g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g] <= '0;
      end else if (wipe_i) begin
        data_q[g] <= '0;
      end else if (restore_i && seq_idx_i == MY_IDX) begin
        data_q[g] <= shadow_q[g];
      end else if (wr_en_i && wr_idx_i == MY_IDX) begin
        data_q[g] <= wr_data_i;
      end
    end

    // shadow: written by save only, read by restore only
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[g] <= '0;
      end else if (save_i && seq_idx_i == MY_IDX) begin
        shadow_q[g] <= data_q[g];
      end
    end

    assign data_o[g] = data_q[g];
  end
endmodule

// File: rtl/pwc_power_seq.sv
module pwc_power_seq
  import pwc_pkg::*;
#(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pdn_req_i,
  input  logic          wake_i,
  output phase_e        phase_o,
  output logic [IW-1:0] idx_o,
  output logic          pend_o,
  output logic          wipe_o,
  output logic          restore_done_o,
  output logic          save_done_o
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  phase_e        phase_q;
  logic [IW-1:0] idx_q;
  logic          pend_q;
  logic          rdone_q;
  logic          last;

  assign last = (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_RESTORE;
      idx_q   <= '0;
      pend_q  <= 1'b0;
      rdone_q <= 1'b0;
    end else begin
      rdone_q <= 1'b0;
      unique case (phase_q)
        PH_RESTORE: begin
          if (pdn_req_i) pend_q <= 1'b1;
          if (last) begin
            idx_q   <= '0;
            pend_q  <= 1'b0;
            rdone_q <= 1'b1;
            phase_q <= (pend_q || pdn_req_i) ? PH_SAVE : PH_RUN;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        PH_RUN: begin
          if (pdn_req_i) begin
            phase_q <= PH_SAVE;
            idx_q   <= '0;
          end
        end
        PH_SAVE: begin
          if (last) begin
            idx_q   <= '0;
            phase_q <= PH_OFF;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        PH_OFF: begin
          if (wake_i) begin
            idx_q   <= '0;
            phase_q <= PH_RESTORE;
          end
        end
        default: phase_q <= PH_RESTORE;
      endcase
    end
  end

  assign phase_o        = phase_q;
  assign idx_o          = idx_q;
  assign pend_o         = pend_q;
  assign wipe_o         = (phase_q == PH_SAVE) && last;
  assign restore_done_o = rdone_q;
  assign save_done_o    = (phase_q == PH_OFF);
endmodule

// File: rtl/persist_wcache.sv
module persist_wcache
  import pwc_pkg::*;
#(
  parameter int N_ENTRY = 16,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int CW      = 32,
  localparam int IW     = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [IW-1:0] cfg_idx_i,
  input  logic          cfg_valid_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic          pdn_req_i,
  input  logic          wake_i,
  output logic          restore_done_o,
  output logic          save_done_o,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_ready_o,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [CW-1:0] mem_wr_cnt_o,
  output logic [CW-1:0] absorb_cnt_o
);
  phase_e                    phase;
  logic [IW-1:0]             seq_idx;
  logic                      pend;
  logic                      wipe;
  logic                      run;
  logic [N_ENTRY-1:0]        valid_q;
  logic [N_ENTRY-1:0][AW-1:0] tag_q;
  logic [N_ENTRY-1:0][DW-1:0] data;
  logic                      hit;
  logic [IW-1:0]             hit_idx;
  logic                      cpu_go;
  logic                      hit_wr;
  logic [CW-1:0]             mem_wr_cnt_q;
  logic [CW-1:0]             absorb_cnt_q;

  pwc_power_seq #(.N(N_ENTRY)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pdn_req_i      (pdn_req_i),
    .wake_i         (wake_i),
    .phase_o        (phase),
    .idx_o          (seq_idx),
    .pend_o         (pend),
    .wipe_o         (wipe),
    .restore_done_o (restore_done_o),
    .save_done_o    (save_done_o)
  );

  assign run = (phase == PH_RUN);

  // static address table
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else if (run && cfg_we_i) begin
      valid_q[cfg_idx_i] <= cfg_valid_i;
      tag_q[cfg_idx_i]   <= cfg_addr_i;
    end
  end

  pwc_tag_match #(.N(N_ENTRY), .AW(AW)) u_match (
    .valid_i (valid_q),
    .tag_i   (tag_q),
    .addr_i  (cpu_addr_i),
    .hit_o   (hit),
    .idx_o   (hit_idx)
  );

  assign cpu_go = cpu_req_i && run;
  assign hit_wr = cpu_go && hit && cpu_we_i;

  pwc_entry_store #(.N(N_ENTRY), .DW(DW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (hit_wr),
    .wr_idx_i  (hit_idx),
    .wr_data_i (cpu_wdata_i),
    .seq_idx_i (seq_idx),
    .restore_i (phase == PH_RESTORE),
    .save_i    (phase == PH_SAVE),
    .wipe_i    (wipe),
    .data_o    (data)
  );

  assign mem_req_o   = cpu_go && !hit;
  assign mem_we_o    = cpu_we_i;
  assign mem_addr_o  = cpu_addr_i;
  assign mem_wdata_o = cpu_wdata_i;
  assign cpu_ready_o = cpu_go && (hit || mem_ready_i);
  assign cpu_rdata_o = hit ? data[hit_idx] : mem_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_wr_cnt_q <= '0;
      absorb_cnt_q <= '0;
    end else begin
      if (hit_wr) absorb_cnt_q <= absorb_cnt_q + 1'b1;
      if (mem_req_o && mem_we_o && mem_ready_i) mem_wr_cnt_q <= mem_wr_cnt_q + 1'b1;
    end
  end

  assign mem_wr_cnt_o = mem_wr_cnt_q;
  assign absorb_cnt_o = absorb_cnt_q;
endmodule

// File: rtl/pwc_chk.sv
module pwc_chk
  import pwc_pkg::*;
#(
  parameter int N  = 16,
  parameter int CW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input phase_e        phase,
  input logic [IW-1:0] seq_idx,
  input logic          pend,
  input logic          pdn_req_i,
  input logic          hit,
  input logic          cpu_req_i,
  input logic          cpu_we_i,
  input logic          cpu_ready_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_ready_i,
  input logic          restore_done_o,
  input logic          save_done_o,
  input logic [CW-1:0] mem_wr_cnt_o,
  input logic [CW-1:0] absorb_cnt_o
);
  logic [15:0] save_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) save_len_q <= '0;
    else         save_len_q <= (phase == PH_SAVE) ? save_len_q + 1'b1 : '0;
  end

  AST_PORT_QUIET_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_RUN) |-> (!cpu_ready_o && !mem_req_o)); // R1

  AST_HIT_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && hit) |-> !mem_req_o); // R5

  AST_ABSORB_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (absorb_cnt_o != $past(absorb_cnt_o)) |-> $past(cpu_req_i && cpu_we_i && hit && cpu_ready_o)); // R5

  AST_MEMWR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_cnt_o != $past(mem_wr_cnt_o)) |-> $past(mem_req_o && mem_we_o && mem_ready_i)); // R6

  AST_SAVE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(save_done_o) |-> (save_len_q == 16'(N))); // R7

  AST_DEFER_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_RESTORE && seq_idx == IW'(N - 1) && (pend || pdn_req_i)) |=> (phase == PH_SAVE)); // R9

  AST_RDONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_done_o |=> !restore_done_o); // R1
endmodule

bind persist_wcache pwc_chk #(.N(N_ENTRY), .CW(CW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .phase          (phase),
  .seq_idx        (seq_idx),
  .pend           (pend),
  .pdn_req_i      (pdn_req_i),
  .hit            (hit),
  .cpu_req_i      (cpu_req_i),
  .cpu_we_i       (cpu_we_i),
  .cpu_ready_o    (cpu_ready_o),
  .mem_req_o      (mem_req_o),
  .mem_we_o       (mem_we_o),
  .mem_ready_i    (mem_ready_i),
  .restore_done_o (restore_done_o),
  .save_done_o    (save_done_o),
  .mem_wr_cnt_o   (mem_wr_cnt_o),
  .absorb_cnt_o   (absorb_cnt_o)
);

// File: tb/sim_persist_wcache.sv
`timescale 1ns/1ps
module sim_persist_wcache;
  localparam int N  = 16;
  localparam int IW = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [IW-1:0] cfg_idx_i = '0;
  logic        cfg_valid_i = 1'b0;
  logic [31:0] cfg_addr_i = '0;
  logic        pdn_req_i = 1'b0;
  logic        wake_i = 1'b0;
  logic        restore_done_o, save_done_o;
  logic        cpu_req_i = 1'b0;
  logic        cpu_we_i = 1'b0;
  logic [31:0] cpu_addr_i = '0;
  logic [31:0] cpu_wdata_i = '0;
  logic        cpu_ready_o;
  logic [31:0] cpu_rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ready_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [31:0] mem_wr_cnt_o, absorb_cnt_o;

  always #2 clk_i = ~clk_i;

  persist_wcache u0 (.*);

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // ---------------- main-memory model ----------------
  logic [31:0] mem_arr [256];
  initial for (int i = 0; i < 256; i++) mem_arr[i] = 32'hA000_0000 + i;

  always @(posedge clk_i) begin
    if (mem_req_o && mem_ready_i && mem_we_o) mem_arr[mem_addr_o[7:0]] <= mem_wdata_o;
    mem_ready_i <= mem_req_o && !mem_ready_i;
    mem_rdata_i <= mem_arr[mem_addr_o[7:0]];
  end

  // ---------------- reference model ----------------
  int          m_phase;   // 0 restore, 1 run, 2 save, 3 off
  int          m_ptr;
  bit          m_pend;
  bit          m_rdone;
  bit          m_valid [N];
  logic [31:0] m_tag    [N];
  logic [31:0] m_data   [N];
  logic [31:0] m_shadow [N];
  logic [31:0] m_memwr, m_absorb;

  function automatic int m_hit(logic [31:0] a);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == a) return i;
    return -1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_phase = 0; m_ptr = 0; m_pend = 0; m_rdone = 0;
      m_memwr = 0; m_absorb = 0;
      for (int i = 0; i < N; i++) begin
        m_valid[i] = 0; m_tag[i] = 0; m_data[i] = 0; m_shadow[i] = 0;
      end
    end else begin
      int h;
      m_rdone = 0;
      case (m_phase)
        0: begin
          m_data[m_ptr] = m_shadow[m_ptr];
          if (pdn_req_i) m_pend = 1;
          if (m_ptr == N - 1) begin
            m_rdone = 1; m_ptr = 0;
            m_phase = m_pend ? 2 : 1;
            m_pend = 0;
          end else m_ptr++;
        end
        1: begin
          h = m_hit(cpu_addr_i);
          if (cpu_req_i && cpu_we_i && h >= 0) begin
            m_data[h] = cpu_wdata_i; m_absorb++;
          end
          if (cpu_req_i && cpu_we_i && h < 0 && mem_ready_i) m_memwr++;
          if (cfg_we_i) begin
            m_valid[cfg_idx_i] = cfg_valid_i; m_tag[cfg_idx_i] = cfg_addr_i;
          end
          if (pdn_req_i) begin m_phase = 2; m_ptr = 0; end
        end
        2: begin
          m_shadow[m_ptr] = m_data[m_ptr];
          if (m_ptr == N - 1) begin
            for (int i = 0; i < N; i++) m_data[i] = 0;
            m_phase = 3; m_ptr = 0;
          end else m_ptr++;
        end
        default: if (wake_i) begin m_phase = 0; m_ptr = 0; end
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      int h;
      bit e_ready, e_mreq;
      h = m_hit(cpu_addr_i);
      e_mreq  = (m_phase == 1) && cpu_req_i && (h < 0);
      e_ready = (m_phase == 1) && cpu_req_i && (h >= 0 || mem_ready_i);
      chk("R1/R4/R6 cpu_ready_o", {31'b0, cpu_ready_o}, {31'b0, e_ready});
      chk("R4/R6 mem_req_o", {31'b0, mem_req_o}, {31'b0, e_mreq});
      if (e_mreq) begin
        chk("R6 mem_addr_o", mem_addr_o, cpu_addr_i);
        chk("R6 mem_wdata_o", mem_wdata_o, cpu_wdata_i);
        chk("R6 mem_we_o", {31'b0, mem_we_o}, {31'b0, cpu_we_i});
      end
      if (e_ready && !cpu_we_i)
        chk("R4/R6 cpu_rdata_o", cpu_rdata_o, (h >= 0) ? m_data[h] : mem_rdata_i);
      chk("R1 restore_done_o", {31'b0, restore_done_o}, {31'b0, m_rdone});
      chk("R7 save_done_o", {31'b0, save_done_o}, {31'b0, m_phase == 3});
      chk("R5 absorb_cnt_o", absorb_cnt_o, m_absorb);
      chk("R6 mem_wr_cnt_o", mem_wr_cnt_o, m_memwr);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic cfg(input logic [IW-1:0] idx, input logic [31:0] a, input logic v);
    @(posedge clk_i); #1;
    cfg_we_i = 1; cfg_idx_i = idx; cfg_addr_i = a; cfg_valid_i = v;
    @(posedge clk_i); #1;
    cfg_we_i = 0;
  endtask

  task automatic acc(input logic we, input logic [31:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output int lat);
    @(posedge clk_i); #1;
    cpu_req_i = 1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = wd;
    lat = 1;
    @(negedge clk_i);
    while (!cpu_ready_o) begin lat++; @(negedge clk_i); end
    rd = cpu_rdata_o;
    @(posedge clk_i); #1;
    cpu_req_i = 0; cpu_we_i = 0;
  endtask

  task automatic pulse_pdn();
    @(posedge clk_i); #1; pdn_req_i = 1;
    @(posedge clk_i); #1; pdn_req_i = 0;
  endtask

  // counts negedges from the drive point until a flag is seen
  task automatic wait_flag(input bit which_save, output int cnt);
    cnt = 0;
    do begin
      @(negedge clk_i); cnt++;
    end while (which_save ? !save_done_o : !restore_done_o);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int lat, cnt;

    // reset state
    #1;
    chk("R1 reset cpu_ready_o", {31'b0, cpu_ready_o}, 32'd0);
    chk("R1 reset counters", absorb_cnt_o | mem_wr_cnt_o, 32'd0);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    wait_flag(0, cnt);
    chk("R1 restore length", cnt, N + 1);

    // R10 duplicate tags: lowest index wins
    cfg(5, 32'h30, 1);
    acc(1, 32'h30, 32'hAAAA_0005, rd, lat);
    chk("R5 hit write latency", lat, 1);
    cfg(0, 32'h30, 1);
    acc(0, 32'h30, 0, rd, lat);
    chk("R10 lowest index serves read", rd, 32'h0);
    chk("R4 hit read latency", lat, 1);
    cfg(0, 32'h30, 0);
    acc(0, 32'h30, 0, rd, lat);
    chk("R10 higher index after invalidate", rd, 32'hAAAA_0005);

    // R5 absorbed writes
    cfg(1, 32'h11, 1);
    cfg(2, 32'h22, 1);
    acc(1, 32'h11, 32'h1111, rd, lat);
    acc(1, 32'h22, 32'h2222, rd, lat);
    chk("R5 absorb count", absorb_cnt_o, 3);
    chk("R5 no main write", mem_wr_cnt_o, 0);

    // R6 pass-through
    acc(0, 32'h40, 0, rd, lat);
    chk("R6 miss read data", rd, 32'hA000_0040);
    chk("R6 miss waits for memory", lat, 2);
    acc(1, 32'h41, 32'hBEEF, rd, lat);
    chk("R6 main write count", mem_wr_cnt_o, 1);
    chk("R6 memory holds data", mem_arr[8'h41], 32'hBEEF);
    acc(0, 32'h41, 0, rd, lat);
    chk("R6 miss read back", rd, 32'hBEEF);

    // R5 endurance: hot address hammered
    for (int k = 0; k < 10; k++) acc(1, 32'h11, 32'h5000 + k, rd, lat);
    chk("R5 absorb after burst", absorb_cnt_o, 13);
    chk("R5 main writes unchanged", mem_wr_cnt_o, 1);

    // R7 save
    @(posedge clk_i); #1; pdn_req_i = 1;
    @(posedge clk_i); #1; pdn_req_i = 0;
    cnt = 1;
    while (!save_done_o) begin @(negedge clk_i); cnt++; end
    chk("R7 save length", cnt, N + 2);

    // R3 config ignored while off; R7 port stalled
    cfg(3, 32'h40, 1);
    @(posedge clk_i); #1; cpu_req_i = 1; cpu_addr_i = 32'h11;
    repeat (3) begin
      @(negedge clk_i);
      chk("R7 ready low while off", {31'b0, cpu_ready_o}, 32'd0);
    end
    @(posedge clk_i); #1; cpu_req_i = 0;

    // R8 wake
    @(posedge clk_i); #1; wake_i = 1;
    @(posedge clk_i); #1; wake_i = 0;
    wait_flag(0, cnt);
    acc(0, 32'h11, 0, rd, lat);
    chk("R8 R2 restored entry 1", rd, 32'h5009);
    acc(0, 32'h22, 0, rd, lat);
    chk("R8 R2 restored entry 2", rd, 32'h2222);
    acc(0, 32'h30, 0, rd, lat);
    chk("R8 R2 restored entry 5", rd, 32'hAAAA_0005);
    acc(0, 32'h40, 0, rd, lat);
    chk("R3 off-phase config dropped", rd, 32'hA000_0040);

    // R9 power-down during restore
    acc(1, 32'h22, 32'h3333, rd, lat);
    pulse_pdn();
    while (!save_done_o) @(negedge clk_i);
    @(posedge clk_i); #1; wake_i = 1;
    @(posedge clk_i); #1; wake_i = 0;
    cnt = 1;
    repeat (3) begin @(negedge clk_i); cnt++; end
    @(posedge clk_i); #1; pdn_req_i = 1;
    @(posedge clk_i); #1; pdn_req_i = 0;
    cnt += 2;
    while (!save_done_o) begin
      @(negedge clk_i); cnt++;
      if (!save_done_o)
        chk("R9 no accepting cycle", {31'b0, cpu_ready_o}, 32'd0);
    end
    chk("R9 deferred save timing", cnt, 2 * N + 3);
    @(posedge clk_i); #1; wake_i = 1;
    @(posedge clk_i); #1; wake_i = 0;
    wait_flag(0, cnt);
    acc(0, 32'h22, 0, rd, lat);
    chk("R9 R2 data after deferred save", rd, 32'h3333);

    repeat (4) @(posedge clk_i);
    finish_run();
  end
endmodule